// File: doc/BRIEF.md
# Horizontal Phase Sequencer with External Resync

This block steps a display controller's scanline through four horizontal phases: a sync window, a wait before active display, active display, and a wait after it. Each phase lasts a count of character clocks taken from its own length input. In this design one clock cycle is one character clock. The sequencer can run on its own, using a timeout to leave the sync window. It can also be pulled into step by a horizontal sync from a separate timing encoder.

A rising edge on the external sync input moves the sequencer straight to the phase after the sync window, whatever phase it is in. Because of this, the internal line and the external line can differ. If the programmed phases are short, several internal lines can finish inside one external line, and each one ends with its own sync window. The line-end strobe marks the start of every internal sync window. A line counter and the line-rate register commit logic use that strobe as their reference event. Two more strobes report how each sync window was left: by an external snap or by timeout.

Top module: `hseq_phase`

## Requirements
- R1: While reset is held and in the first cycle after its release, `phase_o` reads 3 (end wait) and all three strobes are low. At the first clock edge after release the sequencer enters the sync window, and `line_end_o` pulses.
- R2: Phase codes are 0 = sync window, 1 = start wait, 2 = active display, 3 = end wait. With no external edge the phases run 0→1→2→3→0, and each phase holds `phase_o` for L clocks, where L is its length input.
- R3: When the sync window expires with no external edge, the sequencer enters phase 1 and `win_timeout_o` is high for exactly that first cycle of phase 1.
- R4: A rising edge of `ext_hsync_i` seen at a clock edge puts `phase_o` at 1 after that edge, from any phase. `ext_snap_o` is high for that one cycle, and the start-wait length is reloaded.
- R5: `line_end_o` is high for exactly the first cycle of every sync window. A snap never enters the sync window, so a snap never raises `line_end_o`.
- R6: A length input is sampled only when its phase is entered. A change during the phase affects only the next time that phase runs.
- R7: Only rising edges snap. Holding `ext_hsync_i` high causes one snap. A high level that is already present when reset is released is not an edge.
- R8: A length of 0 behaves as a length of 1.
- R9: When the sum of the phase lengths is shorter than the external sync period, more than one internal line (more than one `line_end_o` pulse) falls between two snaps.
- R10: If an external edge arrives in the same cycle the sync window expires, the snap wins: `ext_snap_o` pulses and `win_timeout_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_hsync_i | input | 1 | Horizontal sync level from the timing encoder |
| win_len_i | input | W | Sync-window length in clocks |
| lead_len_i | input | W | Start-wait length in clocks |
| act_len_i | input | W | Active-display length in clocks |
| tail_len_i | input | W | End-wait length in clocks |
| phase_o | output | 2 | Current phase code |
| line_end_o | output | 1 | One-clock pulse on the first cycle of a sync window |
| ext_snap_o | output | 1 | One-clock pulse when an external edge forced phase 1 |
| win_timeout_o | output | 1 | One-clock pulse when the sync window ended by timeout |

## Verification
Every output is registered, so each result appears exactly one clock after the clock edge that sampled its cause. A snap appears one edge after the sync input rises, and a phase change one edge after the last clock of the old phase. The bench changes inputs 1 ns after a rising edge. It compares all outputs 1 ns after the following rising edge against a reference model that it advances once per edge. Directed checks then count pulses or phase durations over windows that begin and end on those same sampling points.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
  typedef enum logic [1:0] {
    PH_WIN  = 2'd0,
    PH_LEAD = 2'd1,
    PH_ACT  = 2'd2,
    PH_TAIL = 2'd3
  } phase_t;

  localparam int unsigned NUM_PHASES = 4;

  function automatic phase_t phase_after(input phase_t p);
    case (p)
      PH_WIN:  return PH_LEAD;
      PH_LEAD: return PH_ACT;
      PH_ACT:  return PH_TAIL;
      default: return PH_WIN;
    endcase
  endfunction
endpackage

// File: rtl/hseq_edge.sv
module hseq_edge #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RST_LVL;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/hseq_len_sel.sv
module hseq_len_sel
  import hseq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  phase_t                           tgt_i,
  input  logic [NUM_PHASES-1:0][W-1:0]     len_i,
  output logic [W-1:0]                     preload_o
);
  logic [NUM_PHASES-1:0][W-1:0] pre;

  // remaining-count preload per phase; zero length saturates to one clock
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_pre
    assign pre[g] = (len_i[g] == '0) ? '0 : len_i[g] - W'(1);
  end

  assign preload_o = pre[tgt_i];
endmodule

// File: rtl/hseq_core.sv
module hseq_core
  import hseq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         snap_i,
  input  logic [W-1:0] preload_i,
  output phase_t       tgt_o,
  output phase_t       phase_o,
  output logic         line_end_o,
  output logic         snap_o,
  output logic         timeout_o
);
  phase_t       phase_q;
  logic [W-1:0] remain_q;
  logic         expire;
  logic         move;

  always_comb begin
    expire = (remain_q == '0);
    move   = snap_i | expire;
    tgt_o  = snap_i ? PH_LEAD : phase_after(phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_TAIL;
      remain_q   <= '0;
      line_end_o <= 1'b0;
      snap_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end else if (move) begin
      phase_q    <= tgt_o;
      remain_q   <= preload_i;
      line_end_o <= ~snap_i & (tgt_o == PH_WIN);
      snap_o     <= snap_i;
      timeout_o  <= ~snap_i & (phase_q == PH_WIN);
    end else begin
      remain_q   <= remain_q - W'(1);
      line_end_o <= 1'b0;
      snap_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/hseq_phase.sv
module hseq_phase
  import hseq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_hsync_i,
  input  logic [W-1:0] win_len_i,
  input  logic [W-1:0] lead_len_i,
  input  logic [W-1:0] act_len_i,
  input  logic [W-1:0] tail_len_i,
  output logic [1:0]   phase_o,
  output logic         line_end_o,
  output logic         ext_snap_o,
  output logic         win_timeout_o
);
  logic [NUM_PHASES-1:0][W-1:0] lens;
  logic                         rise;
  phase_t                       tgt;
  phase_t                       phase;
  logic [W-1:0]                 preload;

  assign lens[PH_WIN]  = win_len_i;
  assign lens[PH_LEAD] = lead_len_i;
  assign lens[PH_ACT]  = act_len_i;
  assign lens[PH_TAIL] = tail_len_i;

  hseq_edge #(.RST_LVL(1'b1)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (ext_hsync_i),
    .rise_o (rise)
  );

  hseq_len_sel #(.W(W)) u_len (
    .tgt_i     (tgt),
    .len_i     (lens),
    .preload_o (preload)
  );

  hseq_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .snap_i     (rise),
    .preload_i  (preload),
    .tgt_o      (tgt),
    .phase_o    (phase),
    .line_end_o (line_end_o),
    .snap_o     (ext_snap_o),
    .timeout_o  (win_timeout_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/hseq_phase_chk.sv
module hseq_phase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_hsync_i,
  input logic [1:0] phase_o,
  input logic       line_end_o,
  input logic       ext_snap_o,
  input logic       win_timeout_o
);
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) && !ext_snap_o |-> phase_o == 2'($past(phase_o) + 2'd1));

  p_timeout_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_timeout_o |-> ($past(phase_o) == 2'd0) && (phase_o == 2'd1));

  p_snap_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_snap_o |-> (phase_o == 2'd1) && $past(ext_hsync_i));

  p_line_end_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_end_o |-> (phase_o == 2'd0) && ($past(phase_o) != 2'd0));

  p_sync_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0) && ($past(phase_o) != 2'd0) |-> line_end_o);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_end_o, ext_snap_o, win_timeout_o}));
endmodule

bind hseq_phase hseq_phase_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_hsync_i   (ext_hsync_i),
  .phase_o       (phase_o),
  .line_end_o    (line_end_o),
  .ext_snap_o    (ext_snap_o),
  .win_timeout_o (win_timeout_o)
);

// File: tb/hseq_phase_bench.sv
`timescale 1ns/1ps
module hseq_phase_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ext = 1'b1;
  logic [W-1:0] lens [4];
  logic [1:0]   phase_o;
  logic         line_end_o, ext_snap_o, win_timeout_o;

  int total = 0;
  int bad = 0;

  int m_phase = 3;
  int m_rem = 0;
  bit m_prev = 1'b1;
  bit e_le, e_sn, e_to;

  always #2.5 clk = ~clk;

  hseq_phase #(.W(W)) u_hseq_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_hsync_i   (ext),
    .win_len_i     (lens[0]),
    .lead_len_i    (lens[1]),
    .act_len_i     (lens[2]),
    .tail_len_i    (lens[3]),
    .phase_o       (phase_o),
    .line_end_o    (line_end_o),
    .ext_snap_o    (ext_snap_o),
    .win_timeout_o (win_timeout_o)
  );

  function automatic int eff(input logic [W-1:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit edge_seen;
    edge_seen = ext && !m_prev;
    m_prev = ext;
    e_le = 0; e_sn = 0; e_to = 0;
    if (edge_seen) begin
      m_phase = 1; m_rem = eff(lens[1]) - 1; e_sn = 1;
    end else if (m_rem == 0) begin
      if (m_phase == 0) e_to = 1;
      m_phase = (m_phase + 1) % 4;
      if (m_phase == 0) e_le = 1;
      m_rem = eff(lens[m_phase]) - 1;
    end else begin
      m_rem--;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    check("R2 phase", int'(phase_o), m_phase);
    check("R5 line_end", int'(line_end_o), int'(e_le));
    check("R4 snap", int'(ext_snap_o), int'(e_sn));
    check("R3 timeout", int'(win_timeout_o), int'(e_to));
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt, snaps;
    void'($urandom(32'd1234));
    lens[0] = 3; lens[1] = 2; lens[2] = 4; lens[3] = 2;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset phase", int'(phase_o), 3);
    check("R1 reset strobes", int'({line_end_o, ext_snap_o, win_timeout_o}), 0);
    rst_n = 1'b1;
    #1;
    check("R1 after release phase", int'(phase_o), 3);
    // R7: ext high at release is no edge; R1 first edge enters window
    tick();
    check("R1 first edge line_end", int'(line_end_o), 1);
    check("R7 no snap on held level", int'(ext_snap_o), 0);
    ext = 1'b0;
    repeat (40) tick();

    // R7: held high gives a single snap
    snaps = 0;
    ext = 1'b1;
    for (int i = 0; i < 30; i++) begin tick(); snaps += int'(ext_snap_o); end
    check("R7 one snap while held", snaps, 1);
    ext = 1'b0;

    // R10: edge on the expiring sync-window cycle
    while (!line_end_o) tick();
    tick(); tick();
    ext = 1'b1;
    tick();
    check("R10 snap wins", int'(ext_snap_o), 1);
    check("R10 no timeout", int'(win_timeout_o), 0);
    ext = 1'b0;

    // R6: change active length mid-phase
    lens[2] = 5;
    while (phase_o != 2'd1) tick();
    while (phase_o != 2'd2) tick();
    lens[2] = 1;
    cnt = 0;
    while (phase_o == 2'd2) begin cnt++; tick(); end
    check("R6 old length kept", cnt, 5);
    while (phase_o != 2'd2) tick();
    cnt = 0;
    while (phase_o == 2'd2) begin cnt++; tick(); end
    check("R6 new length next time", cnt, 1);

    // R8: all zero lengths give one clock per phase
    lens[0] = 0; lens[1] = 0; lens[2] = 0; lens[3] = 0;
    repeat (6) tick();
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] prev;
      prev = phase_o;
      tick();
      if (phase_o != prev) cnt++;
    end
    check("R8 zero acts as one", cnt, 8);

    // R9: several internal lines per external line
    lens[0] = 2; lens[1] = 2; lens[2] = 2; lens[3] = 2;
    ext = 1'b1; tick(); ext = 1'b0;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin tick(); cnt += int'(line_end_o); end
    ext = 1'b1; tick(); ext = 1'b0;
    check("R9 lines between snaps", cnt, 5);

    // random mix of lengths and sync pulses
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0)
        for (int k = 0; k < 4; k++) lens[k] = W'($urandom_range(0, 6));
      ext = ($urandom_range(0, 29) == 0) ? ~ext : ext;
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule